// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block manages one bank of 32 general-purpose pins behind a small word-wide register bus. Software reads the pin levels, which pass through a synchronizer first. It also chooses per pin whether the pin drives a value or is an input, and sets the pull-resistor control lines that go out to the pad ring.

Each pin also has an event detector. Three independent per-pin bits choose what the detector looks for: level or edge, a single edge or both edges, and which polarity. A hit sets a sticky status bit. Software reads the raw status or the status filtered by the enable mask, and clears individual bits by writing ones. One registered interrupt line reports that at least one enabled status bit is set.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, padOe and padOut are all zero, both pull outputs are zero and irqOut is low. Every pin is therefore an input with its interrupt masked.
- R2: Word 0x04 holds the drive value and word 0x08 holds the drive enable. Both read back as written. They appear on padOut and padOe on the clock edge that performs the write.
- R3: Word 0x00 returns the pin levels after a two-flop synchronizer. A change on padIn becomes visible after the second rising clock edge.
- R4: Word 0x0C selects the detection kind per pin (0 = edge, 1 = level). Word 0x14 selects polarity (1 = rising or high, 0 = falling or low). In edge mode with the dual bit clear, only the selected transition sets the pin's bit in raw status (word 0x1C).
- R5: When a bit of word 0x10 is 1, an edge-mode pin sets raw status on both rising and falling transitions, whatever its polarity bit says.
- R6: A level-mode pin sets raw status while its synchronized input is at the active level. Clearing it while that level persists leaves the bit set. Once the level goes inactive, a clear removes it.
- R7: Masked status (word 0x20) equals raw status AND the mask (word 0x18, 1 = enabled). Detection and raw status work whatever the mask holds. irqOut is the OR of all masked bits, registered once, so it follows a mask change one clock later.
- R8: A write to word 0x24 clears exactly those raw status bits written as 1 and leaves every other bit unchanged. Word 0x24 reads as zero. Raw status bits never fall without such a write.
- R9: If a detection event and a clear of the same bit take effect on the same clock edge, the bit stays set.
- R10: Writes to the input word, the raw status word and the masked status word have no effect.
- R11: Word 0x38 holds the pull enables (0 = no resistor) and word 0x34 holds the pull selects (1 = up, 0 = down). Both read back as written and drive padPullEn and padPullSel directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the word inside the bank |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when not reading |
| padIn | input | 32 | Asynchronous pin levels |
| padOut | output | 32 | Drive value per pin |
| padOe | output | 32 | Drive enable per pin |
| padPullEn | output | 32 | Pull resistor enable per pin |
| padPullSel | output | 32 | Pull direction per pin, 1 = up |
| irqOut | output | 1 | Aggregated interrupt request |

## Verification
The assertions watch four things on every cycle. The reset values must hold. Writes to the drive registers must reach the pads, and the drive enable must not move without a write. Raw status bits may fall only under a clear write, and irqOut must match the masked status of the cycle before. The bench scenarios cover behaviour that depends on how the pins were driven: which transitions each mode and polarity accepts, the synchronizer delay, a level re-asserting through a clear, and an event arriving on the same edge as a clear. They also confirm that writes to read-only words leave the observable values unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_PINS = 32;
  localparam int REG_W     = 32;

  localparam int OFS_IN    = 'h00;
  localparam int OFS_OUT   = 'h04;
  localparam int OFS_OE    = 'h08;
  localparam int OFS_TYPE  = 'h0C;
  localparam int OFS_DUAL  = 'h10;
  localparam int OFS_POL   = 'h14;
  localparam int OFS_MASK  = 'h18;
  localparam int OFS_RAW   = 'h1C;
  localparam int OFS_MSTAT = 'h20;
  localparam int OFS_CLR   = 'h24;
  localparam int OFS_PSEL  = 'h34;
  localparam int OFS_PEN   = 'h38;

  typedef logic [BANK_PINS-1:0] pinVec_t;

  typedef enum logic [3:0] {
    REG_NONE, REG_IN, REG_OUT, REG_OE, REG_TYPE, REG_DUAL, REG_POL,
    REG_MASK, REG_RAW, REG_MSTAT, REG_CLR, REG_PSEL, REG_PEN
  } regId_t;

  typedef struct packed {
    logic    wrOut;
    logic    wrOe;
    logic    wrType;
    logic    wrDual;
    logic    wrPol;
    logic    wrMask;
    logic    wrClr;
    logic    wrPullSel;
    logic    wrPullEn;
    pinVec_t wdata;
  } strobes_t;

  typedef struct packed {
    pinVec_t inVal;
    pinVec_t outVal;
    pinVec_t oeVal;
    pinVec_t typeVal;
    pinVec_t dualVal;
    pinVec_t polVal;
    pinVec_t maskVal;
    pinVec_t rawVal;
    pinVec_t pullSelVal;
    pinVec_t pullEnVal;
  } regView_t;

endpackage

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic cur,
  input  logic prev,
  input  logic levelMode,
  input  logic bothEdges,
  input  logic activeHigh,
  output logic hit
);
  logic rise;
  logic fall;

  always_comb begin
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (levelMode)
      hit = activeHigh ? cur : ~cur;
    else if (bothEdges)
      hit = rise | fall;
    else
      hit = activeHigh ? rise : fall;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [REG_W-1:0]    busWdata,
  input  regView_t            view,
  output strobes_t            strb,
  output logic [REG_W-1:0]    busRdata
);
  regId_t regId;
  logic   wrAcc;
  logic   rdAcc;
  pinVec_t rdSel;

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFS_IN):    regId = REG_IN;
      ADDR_W'(OFS_OUT):   regId = REG_OUT;
      ADDR_W'(OFS_OE):    regId = REG_OE;
      ADDR_W'(OFS_TYPE):  regId = REG_TYPE;
      ADDR_W'(OFS_DUAL):  regId = REG_DUAL;
      ADDR_W'(OFS_POL):   regId = REG_POL;
      ADDR_W'(OFS_MASK):  regId = REG_MASK;
      ADDR_W'(OFS_RAW):   regId = REG_RAW;
      ADDR_W'(OFS_MSTAT): regId = REG_MSTAT;
      ADDR_W'(OFS_CLR):   regId = REG_CLR;
      ADDR_W'(OFS_PSEL):  regId = REG_PSEL;
      ADDR_W'(OFS_PEN):   regId = REG_PEN;
      default:            regId = REG_NONE;
    endcase
  end

  assign wrAcc = busSel & busWrite;
  assign rdAcc = busSel & ~busWrite;

  always_comb begin
    strb           = '0;
    strb.wdata     = busWdata[BANK_PINS-1:0];
    strb.wrOut     = wrAcc && (regId == REG_OUT);
    strb.wrOe      = wrAcc && (regId == REG_OE);
    strb.wrType    = wrAcc && (regId == REG_TYPE);
    strb.wrDual    = wrAcc && (regId == REG_DUAL);
    strb.wrPol     = wrAcc && (regId == REG_POL);
    strb.wrMask    = wrAcc && (regId == REG_MASK);
    strb.wrClr     = wrAcc && (regId == REG_CLR);
    strb.wrPullSel = wrAcc && (regId == REG_PSEL);
    strb.wrPullEn  = wrAcc && (regId == REG_PEN);
  end

  always_comb begin
    unique case (regId)
      REG_IN:    rdSel = view.inVal;
      REG_OUT:   rdSel = view.outVal;
      REG_OE:    rdSel = view.oeVal;
      REG_TYPE:  rdSel = view.typeVal;
      REG_DUAL:  rdSel = view.dualVal;
      REG_POL:   rdSel = view.polVal;
      REG_MASK:  rdSel = view.maskVal;
      REG_RAW:   rdSel = view.rawVal;
      REG_MSTAT: rdSel = view.rawVal & view.maskVal;
      REG_PSEL:  rdSel = view.pullSelVal;
      REG_PEN:   rdSel = view.pullEnVal;
      default:   rdSel = '0;
    endcase
  end

  assign busRdata = rdAcc ? REG_W'(rdSel) : '0;
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strb,
  input  pinVec_t  padIn,
  output regView_t view,
  output pinVec_t  padOut,
  output pinVec_t  padOe,
  output pinVec_t  padPullEn,
  output pinVec_t  padPullSel,
  output logic     irqOut
);
  pinVec_t syncChain [SYNC_STAGES];
  pinVec_t syncVal;
  pinVec_t prevVal;
  pinVec_t outReg, oeReg, typeReg, dualReg, polReg, maskReg;
  pinVec_t rawReg, pullSelReg, pullEnReg;
  pinVec_t hitVec;
  pinVec_t clrVec;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= padIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncVal = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevVal <= '0;
    else       prevVal <= syncVal;

  for (genvar p = 0; p < BANK_PINS; p++) begin : g_pin
    gpio_pin_detect u_det (
      .cur        (syncVal[p]),
      .prev       (prevVal[p]),
      .levelMode  (typeReg[p]),
      .bothEdges  (dualReg[p]),
      .activeHigh (polReg[p]),
      .hit        (hitVec[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg     <= '0;
      oeReg      <= '0;
      typeReg    <= '0;
      dualReg    <= '0;
      polReg     <= '0;
      maskReg    <= '0;
      pullSelReg <= '0;
      pullEnReg  <= '0;
    end else begin
      if (strb.wrOut)     outReg     <= strb.wdata;
      if (strb.wrOe)      oeReg      <= strb.wdata;
      if (strb.wrType)    typeReg    <= strb.wdata;
      if (strb.wrDual)    dualReg    <= strb.wdata;
      if (strb.wrPol)     polReg     <= strb.wdata;
      if (strb.wrMask)    maskReg    <= strb.wdata;
      if (strb.wrPullSel) pullSelReg <= strb.wdata;
      if (strb.wrPullEn)  pullEnReg  <= strb.wdata;
    end
  end

  assign clrVec = strb.wrClr ? strb.wdata : '0;

  // a new hit overrides a clear of the same bit
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rawReg <= '0;
    else       rawReg <= (rawReg & ~clrVec) | hitVec;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(rawReg & maskReg);

  always_comb begin
    view.inVal      = syncVal;
    view.outVal     = outReg;
    view.oeVal      = oeReg;
    view.typeVal    = typeReg;
    view.dualVal    = dualReg;
    view.polVal     = polReg;
    view.maskVal    = maskReg;
    view.rawVal     = rawReg;
    view.pullSelVal = pullSelReg;
    view.pullEnVal  = pullEnReg;
  end

  assign padOut     = outReg;
  assign padOe      = oeReg;
  assign padPullEn  = pullEnReg;
  assign padPullSel = pullSelReg;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       padIn,
  output logic [31:0]       padOut,
  output logic [31:0]       padOe,
  output logic [31:0]       padPullEn,
  output logic [31:0]       padPullSel,
  output logic              irqOut
);
  strobes_t strb;
  regView_t regView;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .view     (regView),
    .strb     (strb),
    .busRdata (busRdata)
  );

  gpio_bank_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .padIn      (padIn),
    .view       (regView),
    .padOut     (padOut),
    .padOe      (padOe),
    .padPullEn  (padPullEn),
    .padPullSel (padPullSel),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [31:0]       padOut,
  input logic [31:0]       padOe,
  input logic              irqOut,
  input regView_t          view
);
  logic wrOutReq, wrOeReq, wrClrReq, rdClrReq;
  assign wrOutReq = busSel && busWrite && (busAddr == ADDR_W'(OFS_OUT));
  assign wrOeReq  = busSel && busWrite && (busAddr == ADDR_W'(OFS_OE));
  assign wrClrReq = busSel && busWrite && (busAddr == ADDR_W'(OFS_CLR));
  assign rdClrReq = busSel && !busWrite && (busAddr == ADDR_W'(OFS_CLR));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (padOe == '0 && padOut == '0 && !irqOut && view.rawVal == '0));

  p_out_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrOutReq |=> padOut == $past(busWdata));

  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrOeReq |=> $stable(padOe));

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(view.rawVal & view.maskVal)));

  p_raw_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrClrReq |=> (($past(view.rawVal) & ~view.rawVal) == '0));

  p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdClrReq |-> busRdata == '0);
endmodule

bind gpio_irq_bank gpio_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .irqOut   (irqOut),
  .view     (regView)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_IN = 8'h00, A_OUT = 8'h04, A_OE = 8'h08,
    A_TYPE = 8'h0C, A_DUAL = 8'h10, A_POL = 8'h14, A_MASK = 8'h18,
    A_RAW = 8'h1C, A_MST = 8'h20, A_CLR = 8'h24, A_PSEL = 8'h34, A_PEN = 8'h38;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, padPullEn, padPullSel;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .padPullEn(padPullEn), .padPullSel(padPullSel), .irqOut(irqOut)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    checkEq(req, $sformatf("reg %h", a), v, exp);
  endtask

  task automatic drivePins(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic testReset;
    logic [7:0] addrs [12] = '{A_IN, A_OUT, A_OE, A_TYPE, A_DUAL, A_POL,
                               A_MASK, A_RAW, A_MST, A_CLR, A_PSEL, A_PEN};
    for (int i = 0; i < 12; i++) expectReg("R1", addrs[i], 32'h0);
    checkEq("R1", "padOe", padOe, 32'h0);
    checkEq("R1", "padOut", padOut, 32'h0);
    checkEq("R1", "padPullEn", padPullEn, 32'h0);
    checkEq("R1", "padPullSel", padPullSel, 32'h0);
    checkEq("R1", "irqOut", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic testDrive;
    wrReg(A_OUT, 32'hA5A5_0F0F);
    checkEq("R2", "padOut", padOut, 32'hA5A5_0F0F);
    wrReg(A_OE, 32'hFFFF_0000);
    checkEq("R2", "padOe", padOe, 32'hFFFF_0000);
    expectReg("R2", A_OUT, 32'hA5A5_0F0F);
    expectReg("R2", A_OE, 32'hFFFF_0000);
  endtask

  task automatic testInput;
    logic [31:0] v;
    @(negedge clk);
    padIn = 32'h1234_5678;
    @(posedge clk);
    rdReg(A_IN, v);
    checkEq("R3", "input after one edge", v, 32'h0);
    rdReg(A_IN, v);
    checkEq("R3", "input after two edges", v, 32'h1234_5678);
    drivePins(32'h0);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    expectReg("R3", A_RAW, 32'h0);
  endtask

  task automatic testEdge;
    wrReg(A_POL, 32'h0000_0020);
    drivePins(32'h0000_0060);
    expectReg("R4", A_RAW, 32'h0000_0020);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    drivePins(32'h0);
    expectReg("R4", A_RAW, 32'h0000_0040);
    wrReg(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic testDual;
    wrReg(A_DUAL, 32'h0000_0600);
    wrReg(A_POL, 32'h0000_0220);
    drivePins(32'h0000_0600);
    expectReg("R5", A_RAW, 32'h0000_0600);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    drivePins(32'h0);
    expectReg("R5", A_RAW, 32'h0000_0600);
    wrReg(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic testLevel;
    wrReg(A_POL, 32'h0000_1220);
    wrReg(A_TYPE, 32'h0000_1000);
    expectReg("R6", A_RAW, 32'h0);
    drivePins(32'h0000_1000);
    expectReg("R6", A_RAW, 32'h0000_1000);
    wrReg(A_CLR, 32'h0000_1000);
    expectReg("R6", A_RAW, 32'h0000_1000);
    drivePins(32'h0);
    wrReg(A_CLR, 32'h0000_1000);
    expectReg("R6", A_RAW, 32'h0);
    wrReg(A_TYPE, 32'h0000_3000);
    expectReg("R6", A_RAW, 32'h0000_2000);
    wrReg(A_TYPE, 32'h0);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    expectReg("R6", A_RAW, 32'h0);
  endtask

  task automatic testMask;
    drivePins(32'h0000_0020);
    expectReg("R7", A_RAW, 32'h0000_0020);
    expectReg("R7", A_MST, 32'h0);
    checkEq("R7", "irqOut masked", {31'h0, irqOut}, 32'h0);
    wrReg(A_MASK, 32'h0000_0020);
    checkEq("R7", "irqOut same edge as mask write", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    checkEq("R7", "irqOut one edge later", {31'h0, irqOut}, 32'h1);
    expectReg("R7", A_MST, 32'h0000_0020);
    wrReg(A_MASK, 32'h0000_0040);
    expectReg("R7", A_MST, 32'h0);
    checkEq("R7", "irqOut after unmask", {31'h0, irqOut}, 32'h0);
    wrReg(A_MASK, 32'h0);
  endtask

  task automatic testClear;
    drivePins(32'h0000_0220);
    expectReg("R8", A_RAW, 32'h0000_0220);
    wrReg(A_CLR, 32'h0000_0200);
    expectReg("R8", A_RAW, 32'h0000_0020);
    expectReg("R8", A_CLR, 32'h0);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    expectReg("R8", A_RAW, 32'h0);
  endtask

  task automatic testRace;
    drivePins(32'h0000_0020);
    expectReg("R9", A_RAW, 32'h0000_0200);
    @(negedge clk);
    padIn = 32'h0000_0220;
    @(posedge clk);
    @(posedge clk);
    wrReg(A_CLR, 32'h0000_0200);
    expectReg("R9", A_RAW, 32'h0000_0200);
    wrReg(A_CLR, 32'h0000_0200);
    expectReg("R9", A_RAW, 32'h0);
  endtask

  task automatic testReadOnly;
    wrReg(A_MASK, 32'hFFFF_FFFF);
    wrReg(A_IN, 32'hFFFF_FFFF);
    wrReg(A_RAW, 32'hFFFF_FFFF);
    wrReg(A_MST, 32'hFFFF_FFFF);
    expectReg("R10", A_IN, 32'h0000_0220);
    expectReg("R10", A_RAW, 32'h0);
    expectReg("R10", A_MST, 32'h0);
    checkEq("R10", "irqOut", {31'h0, irqOut}, 32'h0);
    wrReg(A_MASK, 32'h0);
  endtask

  task automatic testPull;
    wrReg(A_PSEL, 32'hF0F0_1234);
    wrReg(A_PEN, 32'h00FF_FF00);
    checkEq("R11", "padPullSel", padPullSel, 32'hF0F0_1234);
    checkEq("R11", "padPullEn", padPullEn, 32'h00FF_FF00);
    expectReg("R11", A_PSEL, 32'hF0F0_1234);
    expectReg("R11", A_PEN, 32'h00FF_FF00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDrive();
    testInput();
    testEdge();
    testDual();
    testLevel();
    testMask();
    testClear();
    testRace();
    testReadOnly();
    testPull();
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule